// File: doc/BRIEF.md
# Strap-Addressed Configuration Register Slave for a Two-Wire Bus

This block is a slave on a standard two-wire serial bus (I2C). It holds two 6-bit configuration registers, called A and B, and a read-only 5-bit snapshot of a parallel input port. The bus lines are sampled on a fast system clock through two-flop synchronizers. The block decodes START and STOP itself and answers one 7-bit address, which a strap input selects. It never drives SCL. It pulls SDA low through an open-drain enable output.

There is no pointer byte. A read always returns register A first, then register B, then the port snapshot. When the master keeps acknowledging after that, the snapshot byte repeats until the master stops acknowledging. A write carries one data byte. Its two top bits pick the target register and its six low bits carry the new value. The snapshot is taken on the first SCL rising edge after each START, so its value cannot change while it is being read. A repeated START is accepted at any point in a transaction.

Top module: `cfgi2c_top`

## Requirements
- R1: A STOP (SDA rising while SCL is high) ends any transaction. After it, SDA is released and stays released until the next START (SDA falling while SCL is high).
- R2: With the strap at 1 the block answers address 7'b1001110. With the strap at 0 it answers 7'b0110111. It acknowledges by pulling SDA low during the 9th SCL high phase of the address byte.
- R3: The block does not acknowledge the general call address 7'b0000000 or any other address that differs from its own, and it leaves SDA released for the rest of that transaction.
- R4: A write data byte with bits 7:6 = 2'b00 loads bits 5:0 into register A, and one with bits 7:6 = 2'b01 loads bits 5:0 into register B. Each written byte is acknowledged, and neither register changes at any other time.
- R5: A write data byte with bit 7 = 1 is acknowledged and discarded, so registers A and B keep their values.
- R6: A read returns, MSB first, {2'b00, A}, then {2'b00, B}, then {3'b000, snapshot}. The next byte is sent each time the master acknowledges.
- R7: The snapshot holds the input-port value sampled at the first SCL rising edge after a START. Port changes after that point do not appear in the current transaction.
- R8: Every read byte after the snapshot byte repeats the snapshot.
- R9: When the master does not acknowledge a read byte, the block releases SDA. Further SCL clocks then read as all ones until the next START or STOP.
- R10: A repeated START in the middle of a transaction starts address decoding again. For example, a read of A can be followed directly by a write.
- R11: After reset, SDA is released and registers A and B hold 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel | input | 1 | Strap choosing one of the two slave addresses |
| port_in | input | 5 | Parallel input port that is snapshotted |
| reg_a_q | output | 6 | Current content of register A |
| reg_b_q | output | 6 | Current content of register B |

## Verification
The assertions check the following on every cycle:
- Registers A and B change only on a decoded write strobe, and only to the value that strobe selects.
- A write with the high selection bit set leaves both registers unchanged.
- The snapshot is loaded from the port on its capture strobe and holds its value otherwise.
- SDA is released after every STOP.

The bench scenarios cover what needs whole bus transactions:
- address matching and acknowledge timing across all 128 addresses for both strap values;
- the A, B, snapshot order and the repeated snapshot;
- the capture instant relative to START;
- the bus after a master NACK;
- a write that follows a repeated START.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

    localparam int BYTE_W  = 8;
    localparam int CFG_W   = 6;
    localparam int PORT_W  = 5;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int SEL_W   = BYTE_W - CFG_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } bus_state_e;

    localparam logic [1:0] SRC_A    = 2'd0;
    localparam logic [1:0] SRC_B    = 2'd1;
    localparam logic [1:0] SRC_SNAP = 2'd2;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_evt_t;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [CFG_W-1:0] val;
    } wr_req_t;

    function automatic logic [6:0] pick_addr(input logic strap,
                                             input logic [6:0] a_one,
                                             input logic [6:0] a_zero);
        return strap ? a_one : a_zero;
    endfunction

endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync
    import cfgi2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt
);
    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign cur[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prv <= '1;
        else     prv <= cur;
    end

    always_comb begin
        evt.start = cur[0] & prv[0] & prv[1] & ~cur[1];
        evt.stop  = cur[0] & prv[0] & ~prv[1] & cur[1];
        evt.rise  = cur[0] & ~prv[0];
        evt.fall  = ~cur[0] & prv[0];
        evt.sda   = cur[1];
    end
endmodule

// File: rtl/cfgi2c_engine.sv
module cfgi2c_engine
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] ADDR_SEL1 = 7'b1001110,
    parameter logic [6:0] ADDR_SEL0 = 7'b0110111
) (
    input  logic              clk,
    input  logic              rst,
    input  line_evt_t         evt,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [1:0]        rd_sel,
    output wr_req_t           wr,
    output logic              snap_stb,
    output logic              sda_oe
);
    bus_state_e        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              rw;
    logic              mack;
    logic              snap_pend;
    logic [1:0]        idx;
    logic [6:0]        my_addr;

    assign my_addr = pick_addr(addr_sel, ADDR_SEL1, ADDR_SEL0);
    assign rd_sel  = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            txreg     <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            snap_pend <= 1'b0;
            idx       <= SRC_A;
            wr        <= '0;
            snap_stb  <= 1'b0;
        end else begin
            wr.en    <= 1'b0;
            snap_stb <= 1'b0;
            if (evt.start) begin
                st        <= ST_ADDR;
                cnt       <= '0;
                idx       <= SRC_A;
                snap_pend <= 1'b1;
            end else if (evt.stop) begin
                st        <= ST_IDLE;
                snap_pend <= 1'b0;
            end else begin
                if (evt.rise && snap_pend) begin
                    snap_stb  <= 1'b1;
                    snap_pend <= 1'b0;
                end
                unique case (st)
                    ST_ADDR, ST_WDAT: begin
                        if (evt.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.fall && cnt == CNT_W'(BYTE_W)) begin
                            cnt <= '0;
                            if (st == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == my_addr) begin
                                    st <= ST_AACK;
                                    rw <= shreg[0];
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else begin
                                st     <= ST_WACK;
                                wr.en  <= 1'b1;
                                wr.sel <= shreg[BYTE_W-1:CFG_W];
                                wr.val <= shreg[CFG_W-1:0];
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.fall) begin
                            if (rw) begin
                                st    <= ST_RDAT;
                                txreg <= rd_byte;
                            end else begin
                                st <= ST_WDAT;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (evt.fall) st <= ST_WDAT;
                    end
                    ST_RDAT: begin
                        if (evt.rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.fall) begin
                            if (cnt == CNT_W'(BYTE_W)) begin
                                st  <= ST_RACK;
                                cnt <= '0;
                            end else begin
                                txreg <= {txreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            mack <= ~evt.sda;
                            if (!evt.sda && idx != SRC_SNAP) idx <= idx + 2'd1;
                        end else if (evt.fall) begin
                            if (mack) begin
                                st    <= ST_RDAT;
                                txreg <= rd_byte;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (st)
            ST_AACK, ST_WACK: sda_oe = 1'b1;
            ST_RDAT:          sda_oe = ~txreg[BYTE_W-1];
            default:          sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfgi2c_regs.sv
module cfgi2c_regs
    import cfgi2c_pkg::*;
#(
    parameter logic [CFG_W-1:0] RST_A = '0,
    parameter logic [CFG_W-1:0] RST_B = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              snap_stb,
    input  logic [PORT_W-1:0] port_in,
    input  logic [1:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CFG_W-1:0]  reg_a,
    output logic [CFG_W-1:0]  reg_b,
    output logic [PORT_W-1:0] snap_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reg_a  <= RST_A;
            reg_b  <= RST_B;
            snap_q <= '0;
        end else begin
            if (wr.en) begin
                case (wr.sel)
                    SEL_W'(0): reg_a <= wr.val;
                    SEL_W'(1): reg_b <= wr.val;
                    default: ;
                endcase
            end
            if (snap_stb) snap_q <= port_in;
        end
    end

    always_comb begin
        case (rd_sel)
            SRC_A:   rd_byte = {{(BYTE_W-CFG_W){1'b0}}, reg_a};
            SRC_B:   rd_byte = {{(BYTE_W-CFG_W){1'b0}}, reg_b};
            default: rd_byte = {{(BYTE_W-PORT_W){1'b0}}, snap_q};
        endcase
    end
endmodule

// File: rtl/cfgi2c_top.sv
module cfgi2c_top
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0] ADDR_SEL1   = 7'b1001110,
    parameter logic [6:0] ADDR_SEL0   = 7'b0110111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              addr_sel,
    input  logic [PORT_W-1:0] port_in,
    output logic [CFG_W-1:0]  reg_a_q,
    output logic [CFG_W-1:0]  reg_b_q
);
    line_evt_t         evt;
    wr_req_t           wr_req;
    logic              snap_stb;
    logic [1:0]        rd_sel;
    logic [BYTE_W-1:0] rd_byte;
    logic [PORT_W-1:0] snap_q;
    logic              stop_evt;

    assign stop_evt = evt.stop;

    cfgi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    cfgi2c_engine #(.ADDR_SEL1(ADDR_SEL1), .ADDR_SEL0(ADDR_SEL0)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_byte  (rd_byte),
        .rd_sel   (rd_sel),
        .wr       (wr_req),
        .snap_stb (snap_stb),
        .sda_oe   (sda_oe)
    );

    cfgi2c_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_req),
        .snap_stb (snap_stb),
        .port_in  (port_in),
        .rd_sel   (rd_sel),
        .rd_byte  (rd_byte),
        .reg_a    (reg_a_q),
        .reg_b    (reg_b_q),
        .snap_q   (snap_q)
    );
endmodule

// File: rtl/cfgi2c_chk.sv
module cfgi2c_chk
    import cfgi2c_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              stop_evt,
    input wr_req_t           wr,
    input logic              snap_stb,
    input logic [PORT_W-1:0] port_in,
    input logic [PORT_W-1:0] snap_q,
    input logic [CFG_W-1:0]  reg_a,
    input logic [CFG_W-1:0]  reg_b
);
    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    // R4
    write_a_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == 2'b00) |=> reg_a == $past(wr.val));

    // R4
    write_b_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == 2'b01) |=> reg_b == $past(wr.val));

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> ($stable(reg_a) && $stable(reg_b)));

    // R5
    discard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel[1]) |=> ($stable(reg_a) && $stable(reg_b)));

    // R7
    snap_load_chk: assert property (@(posedge clk) disable iff (rst)
        snap_stb |=> snap_q == $past(port_in));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !snap_stb |=> $stable(snap_q));

    // R11
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && reg_a == '0 && reg_b == '0));
endmodule

bind cfgi2c_top cfgi2c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .stop_evt (stop_evt),
    .wr       (wr_req),
    .snap_stb (snap_stb),
    .port_in  (port_in),
    .snap_q   (snap_q),
    .reg_a    (reg_a_q),
    .reg_b    (reg_b_q)
);

// File: tb/cfgi2c_top_tb.sv
module cfgi2c_top_tb;
    localparam int H = 8;
    localparam logic [6:0] AD1 = 7'b1001110;
    localparam logic [6:0] AD0 = 7'b0110111;

    logic clk = 0;
    logic rst = 1;
    logic scl_m = 1;
    logic sda_m = 1;
    logic addr_sel = 1;
    logic [4:0] port_in = 0;
    logic sda_oe;
    logic [5:0] reg_a_q, reg_b_q;
    wire  sda_bus = sda_m & ~sda_oe;

    int ntests = 0;
    int nfail  = 0;
    logic [5:0] ma = 0, mb = 0;

    always #10 clk = ~clk;

    cfgi2c_top u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .port_in(port_in), .reg_a_q(reg_a_q), .reg_b_q(reg_b_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wh();   repeat (H)   @(negedge clk); endtask
    task automatic hh();   repeat (H/2) @(negedge clk); endtask
    task automatic hold(); repeat (2)   @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1; wh(); scl_m = 1; wh(); sda_m = 0; wh(); scl_m = 0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 0; wh(); scl_m = 1; wh(); sda_m = 1; wh();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wh(); scl_m = 1; wh(); scl_m = 0; hold();
        end
        sda_m = 1; wh(); scl_m = 1; hh(); ack = ~sda_bus; hh(); scl_m = 0; hold();
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            wh(); scl_m = 1; hh(); b[i] = sda_bus; hh(); scl_m = 0; hold();
        end
        sda_m = ~ack; wh(); scl_m = 1; wh(); scl_m = 0; hold(); sda_m = 1;
    endtask

    task automatic write_reg(input logic [7:0] d);
        logic ack;
        bus_start();
        put_byte({AD1, 1'b0}, ack); chk("R2 write addr ack", ack, 1);
        put_byte(d, ack);
        chk(d[7] ? "R5 discard byte ack" : "R4 data ack", ack, 1);
        bus_stop();
        if (d[7:6] == 2'b00) ma = d[5:0];
        if (d[7:6] == 2'b01) mb = d[5:0];
    endtask

    task automatic read_ab();
        logic ack;
        logic [7:0] b;
        bus_start();
        put_byte({AD1, 1'b1}, ack); chk("R2 read addr ack", ack, 1);
        get_byte(1, b); chk("R6 byte A", b, {2'b00, ma});
        get_byte(0, b); chk("R6 byte B", b, {2'b00, mb});
        bus_stop();
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        nfail++; ntests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin : main
        logic ack;
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 sda_oe", sda_oe, 0);
        chk("R11 reg A", reg_a_q, 0);
        chk("R11 reg B", reg_b_q, 0);
        read_ab();

        // R2 / R3: sweep every address for both strap values
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            for (int a = 0; a < 128; a++) begin
                logic exp_ack;
                exp_ack = (a[6:0] == (s[0] ? AD1 : AD0));
                bus_start();
                put_byte({a[6:0], 1'b0}, ack);
                if (exp_ack) chk("R2 own address ack", ack, 1);
                else         chk("R3 foreign/general call nack", ack, 0);
                if (!exp_ack) begin
                    put_byte(8'h00, ack);
                    chk("R3 stays silent", ack, 0);
                end
                bus_stop();
                chk("R1 released after stop", sda_oe, 0);
            end
        end
        addr_sel = 1;
        chk("R3 regs untouched by foreign traffic", {reg_a_q, reg_b_q}, 12'h000);

        // R4 / R5: sweep data byte values
        for (int v = 0; v < 256; v += 5) begin
            write_reg(v[7:0]);
            chk(v[7] ? "R5 reg A kept" : "R4 reg A", reg_a_q, ma);
            chk(v[7] ? "R5 reg B kept" : "R4 reg B", reg_b_q, mb);
            if ((v % 20) == 0) read_ab();
        end
        write_reg(8'h3F); write_reg(8'h6A);
        write_reg(8'hC0); write_reg(8'h80);
        chk("R5 reg A after 1x writes", reg_a_q, 6'h3F);
        chk("R5 reg B after 1x writes", reg_b_q, 6'h2A);

        // R1: address then STOP with no data
        bus_start(); put_byte({AD1, 1'b0}, ack); bus_stop();
        chk("R1 no write on bare stop A", reg_a_q, ma);
        chk("R1 no write on bare stop B", reg_b_q, mb);
        chk("R1 released", sda_oe, 0);

        // R6 / R7 / R8: full read sequence with port moving around the capture
        for (int k = 0; k < 4; k++) begin
            logic [4:0] p;
            p = 5'(k * 11 + 3);
            port_in = ~p;
            bus_start();
            port_in = p;            // before the first SCL rise after START
            put_byte({AD1, 1'b1}, ack);
            chk("R2 read ack", ack, 1);
            port_in = ~p;           // after capture: must not show
            get_byte(1, b); chk("R6 first is A", b, {2'b00, ma});
            get_byte(1, b); chk("R6 second is B", b, {2'b00, mb});
            get_byte(1, b); chk("R7 snapshot byte", b, {3'b000, p});
            get_byte(1, b); chk("R8 snapshot repeats", b, {3'b000, p});
            get_byte(0, b); chk("R8 snapshot repeats again", b, {3'b000, p});
            bus_stop();
        end

        // R9: NACK ends read; further clocks read ones
        bus_start(); put_byte({AD1, 1'b1}, ack);
        get_byte(0, b); chk("R9 byte before nack", b, {2'b00, ma});
        get_byte(0, b); chk("R9 bus released after nack", b, 8'hFF);
        chk("R9 sda_oe low", sda_oe, 0);
        bus_stop();

        // R10: read A, repeated START, write B
        bus_start(); put_byte({AD1, 1'b1}, ack);
        get_byte(0, b); chk("R10 read A", b, {2'b00, ma});
        bus_start();
        put_byte({AD1, 1'b0}, ack); chk("R10 addr after repeated start", ack, 1);
        put_byte(8'h55, ack);       chk("R10 data ack", ack, 1);
        bus_stop();
        mb = 6'h15;
        chk("R10 reg B written", reg_b_q, 6'h15);
        read_ab();

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule